// File: doc/BRIEF.md
# Bit-Slice Register File, Q Register and Destination Shifter

This block is the write-back and storage half of a 4-bit microprogrammed bit-slice datapath. It holds a 16-word register file with two read addresses, A and B. It also holds a single working register called Q. Each cycle an external ALU returns its result F. A 3-bit destination code then chooses three things: what is written back to the word at address B, whether Q is loaded, and whether the stored value is shifted one place towards the MSB, shifted one place towards the LSB, or stored unshifted.

The two read operands are registered copies of the addressed words, taken at the same clock edge as the write-back. An operand therefore never shows a value written in the same cycle. The Y output normally carries F, but shows the A operand for one destination code. Each shifter has a serial port at its LSB end and at its MSB end. These would be bidirectional pins on a real slice. Here each is split into an input, an output and an output enable, so that adjacent slices can be chained. The port at the far end of the shift feeds the bit shifted in, and the port at the near end drives out the bit shifted away.

Top module: `bitslice_store`

## Requirements
- R1: Destination code 0 loads F into Q at the rising clock edge and writes nothing to the register file.
- R2: Destination code 1 changes neither the register file nor Q.
- R3: An active-high synchronous reset clears Q to 0. For codes 1, 2, 3, 5 and 7, Q keeps its value.
- R4: Codes 2 and 3 write F unshifted into the word addressed by B.
- R5: Codes 4 and 5 are down shifts. The word at B receives {ram_msb_in, F[3:1]}, and ram_lsb_out drives F[0] with ram_lsb_oe high. Q-side: q_lsb_out drives Q[0] with q_lsb_oe high. Code 4 also loads Q with {q_msb_in, Q[3:1]}.
- R6: Codes 6 and 7 are up shifts. The word at B receives {F[2:0], ram_lsb_in}, and ram_msb_out drives F[3] with ram_msb_oe high. Q-side: q_msb_out drives Q[3] with q_msb_oe high. Code 6 also loads Q with {Q[2:0], q_lsb_in}.
- R7: For codes 0 to 3 all four output enables are low. For a shift code, only the two enables on the side the bits leave from are high.
- R8: Y equals a_data when the code is 2, and F for every other code.
- R9: a_data and b_data show the words at the A and B addresses sampled at a clock edge, valid from that edge until the next one. A word written at the same edge appears with its old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of Q |
| dest | input | 3 | Destination and shift code |
| a_addr | input | 4 | Read address of operand A |
| b_addr | input | 4 | Read address of operand B and write address |
| f | input | 4 | ALU result |
| ram_lsb_in | input | 1 | Serial bit into the register-file LSB on an up shift |
| ram_msb_in | input | 1 | Serial bit into the register-file MSB on a down shift |
| q_lsb_in | input | 1 | Serial bit into the Q LSB on an up shift |
| q_msb_in | input | 1 | Serial bit into the Q MSB on a down shift |
| a_data | output | 4 | Registered A operand |
| b_data | output | 4 | Registered B operand |
| q_data | output | 4 | Q register contents |
| y | output | 4 | Data output, F or the A operand |
| ram_lsb_out | output | 1 | F[0] driven out on a down shift |
| ram_lsb_oe | output | 1 | Enable for ram_lsb_out |
| ram_msb_out | output | 1 | F[3] driven out on an up shift |
| ram_msb_oe | output | 1 | Enable for ram_msb_out |
| q_lsb_out | output | 1 | Q[0] driven out on a down shift |
| q_lsb_oe | output | 1 | Enable for q_lsb_out |
| q_msb_out | output | 1 | Q[3] driven out on an up shift |
| q_msb_oe | output | 1 | Enable for q_msb_out |

## Verification
First, all sixteen words are filled with unshifted writes. This fixes a known state against which later reads can be checked. A directed sequence then writes and reads the same address in one cycle, which shows whether reads see old data or bypassed new data. It also runs each destination code once with distinct serial-input values, so that a swapped fill bit or a swapped port enable gives a different word. A long random stream mixes all codes, addresses and serial bits. Shifts repeated on Q expose any wrong bit ordering, and code 1 and code 2 cycles show whether anything is written when it should not be.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [2:0] {
    DST_QLOAD  = 3'd0,
    DST_NONE   = 3'd1,
    DST_RAM_YA = 3'd2,
    DST_RAM    = 3'd3,
    DST_DN_RQ  = 3'd4,
    DST_DN_R   = 3'd5,
    DST_UP_RQ  = 3'd6,
    DST_UP_R   = 3'd7
  } dest_t;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_DOWN = 2'd1,
    SH_UP   = 2'd2
  } shdir_t;

  typedef struct packed {
    logic   ram_we;
    logic   q_we;
    logic   q_from_f;
    logic   y_sel_a;
    shdir_t dir;
  } dec_t;

endpackage

// File: rtl/bss_dest_decode.sv
module bss_dest_decode
  import bss_pkg::*;
(
  input  logic [2:0] dest,
  output dec_t       dec
);

  always_comb begin
    dec = '{ram_we: 1'b0, q_we: 1'b0, q_from_f: 1'b0, y_sel_a: 1'b0, dir: SH_NONE};
    case (dest_t'(dest))
      DST_QLOAD:  begin dec.q_we = 1'b1; dec.q_from_f = 1'b1; end
      DST_NONE:   ;
      DST_RAM_YA: begin dec.ram_we = 1'b1; dec.y_sel_a = 1'b1; end
      DST_RAM:    dec.ram_we = 1'b1;
      DST_DN_RQ:  begin dec.ram_we = 1'b1; dec.q_we = 1'b1; dec.dir = SH_DOWN; end
      DST_DN_R:   begin dec.ram_we = 1'b1; dec.dir = SH_DOWN; end
      DST_UP_RQ:  begin dec.ram_we = 1'b1; dec.q_we = 1'b1; dec.dir = SH_UP; end
      DST_UP_R:   begin dec.ram_we = 1'b1; dec.dir = SH_UP; end
      default:    ;
    endcase
  end

endmodule

// File: rtl/bss_shifter.sv
module bss_shifter
  import bss_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] din,
  input  shdir_t       dir,
  input  logic         lsb_in,
  input  logic         msb_in,
  output logic [W-1:0] dout,
  output logic         lsb_out,
  output logic         lsb_oe,
  output logic         msb_out,
  output logic         msb_oe
);

  always_comb begin
    dout    = din;
    lsb_out = 1'b0;
    lsb_oe  = 1'b0;
    msb_out = 1'b0;
    msb_oe  = 1'b0;
    case (dir)
      SH_DOWN: begin
        dout    = {msb_in, din[W-1:1]};
        lsb_out = din[0];
        lsb_oe  = 1'b1;
      end
      SH_UP: begin
        dout    = {din[W-2:0], lsb_in};
        msb_out = din[W-1];
        msb_oe  = 1'b1;
      end
      default: ;
    endcase
  end

  // R7: a shifter never drives both of its end ports at once
  always_comb begin
    a_r7_one_port: assert ($onehot0({lsb_oe, msb_oe}))
      else $error("both shift ports enabled");
  end

endmodule

// File: rtl/bss_regfile.sv
module bss_regfile #(
  parameter int W  = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // Registered reads sample the array before this edge's write lands.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/bitslice_store.sv
module bitslice_store
  import bss_pkg::*;
#(
  parameter int W  = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    dest,
  input  logic [AW-1:0] a_addr,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  f,
  input  logic          ram_lsb_in,
  input  logic          ram_msb_in,
  input  logic          q_lsb_in,
  input  logic          q_msb_in,
  output logic [W-1:0]  a_data,
  output logic [W-1:0]  b_data,
  output logic [W-1:0]  q_data,
  output logic [W-1:0]  y,
  output logic          ram_lsb_out,
  output logic          ram_lsb_oe,
  output logic          ram_msb_out,
  output logic          ram_msb_oe,
  output logic          q_lsb_out,
  output logic          q_lsb_oe,
  output logic          q_msb_out,
  output logic          q_msb_oe
);

  dec_t         dec;
  logic [W-1:0] ram_wdata;
  logic [W-1:0] q_shifted;
  logic [W-1:0] q_reg;

  bss_dest_decode u_dec (
    .dest (dest),
    .dec  (dec)
  );

  bss_shifter #(.W(W)) u_ram_sh (
    .din     (f),
    .dir     (dec.dir),
    .lsb_in  (ram_lsb_in),
    .msb_in  (ram_msb_in),
    .dout    (ram_wdata),
    .lsb_out (ram_lsb_out),
    .lsb_oe  (ram_lsb_oe),
    .msb_out (ram_msb_out),
    .msb_oe  (ram_msb_oe)
  );

  bss_shifter #(.W(W)) u_q_sh (
    .din     (q_reg),
    .dir     (dec.dir),
    .lsb_in  (q_lsb_in),
    .msb_in  (q_msb_in),
    .dout    (q_shifted),
    .lsb_out (q_lsb_out),
    .lsb_oe  (q_lsb_oe),
    .msb_out (q_msb_out),
    .msb_oe  (q_msb_oe)
  );

  bss_regfile #(.W(W), .AW(AW)) u_rf (
    .clk     (clk),
    .we      (dec.ram_we),
    .waddr   (b_addr),
    .wdata   (ram_wdata),
    .raddr_a (a_addr),
    .raddr_b (b_addr),
    .rdata_a (a_data),
    .rdata_b (b_data)
  );

  always_ff @(posedge clk) begin
    if (rst)           q_reg <= '0;
    else if (dec.q_we) q_reg <= dec.q_from_f ? f : q_shifted;
  end

  assign q_data = q_reg;
  assign y      = dec.y_sel_a ? a_data : f;

  // R1: code 0 moves F into Q
  a_r1_q_load: assert property (@(posedge clk) disable iff (rst)
    (dest == 3'd0) |=> (q_data == $past(f)));

  // R3: codes that do not target Q leave it alone
  a_r3_q_hold: assert property (@(posedge clk) disable iff (rst)
    (dest == 3'd1 || dest == 3'd2 || dest == 3'd3 || dest == 3'd5 || dest == 3'd7)
    |=> $stable(q_data));

  // R5: Q down shift fills the MSB from the serial input
  a_r5_q_down: assert property (@(posedge clk) disable iff (rst)
    (dest == 3'd4) |=> (q_data == {$past(q_msb_in), $past(q_data[W-1:1])}));

  // R6: Q up shift fills the LSB from the serial input
  a_r6_q_up: assert property (@(posedge clk) disable iff (rst)
    (dest == 3'd6) |=> (q_data == {$past(q_data[W-2:0]), $past(q_lsb_in)}));

  // R7: no port drives during unshifted codes
  a_r7_quiet_ports: assert property (@(posedge clk) disable iff (rst)
    (dest[2] == 1'b0) |-> !(ram_lsb_oe || ram_msb_oe || q_lsb_oe || q_msb_oe));

endmodule

// File: tb/bitslice_store_test.sv
module bitslice_store_test;

  localparam int PERIOD = 10;
  localparam int W = 4;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    dest = 3'd1;
  logic [AW-1:0] a_addr = '0;
  logic [AW-1:0] b_addr = '0;
  logic [W-1:0]  f = '0;
  logic          ram_lsb_in = 1'b0, ram_msb_in = 1'b0, q_lsb_in = 1'b0, q_msb_in = 1'b0;
  logic [W-1:0]  a_data, b_data, q_data, y;
  logic          ram_lsb_out, ram_lsb_oe, ram_msb_out, ram_msb_oe;
  logic          q_lsb_out, q_lsb_oe, q_msb_out, q_msb_oe;

  int n_vec = 0;
  int n_bad = 0;

  // Reference state
  logic [W-1:0] m_mem [DEPTH];
  bit           m_val [DEPTH];
  logic [W-1:0] m_q, m_a, m_b;
  bit           m_av = 0, m_bv = 0;

  always #(PERIOD/2) clk = ~clk;

  bitslice_store #(.W(W), .AW(AW)) uut (
    .clk(clk), .rst(rst), .dest(dest), .a_addr(a_addr), .b_addr(b_addr), .f(f),
    .ram_lsb_in(ram_lsb_in), .ram_msb_in(ram_msb_in),
    .q_lsb_in(q_lsb_in), .q_msb_in(q_msb_in),
    .a_data(a_data), .b_data(b_data), .q_data(q_data), .y(y),
    .ram_lsb_out(ram_lsb_out), .ram_lsb_oe(ram_lsb_oe),
    .ram_msb_out(ram_msb_out), .ram_msb_oe(ram_msb_oe),
    .q_lsb_out(q_lsb_out), .q_lsb_oe(q_lsb_oe),
    .q_msb_out(q_msb_out), .q_msb_oe(q_msb_oe)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Apply one cycle: drive, check before the edge, then advance the reference.
  task automatic step(input logic [2:0] d, input logic [AW-1:0] aa, input logic [AW-1:0] bb,
                      input logic [W-1:0] ff, input logic [3:0] sin);
    logic [W-1:0] ey, rw;
    logic [5:0]   eoe;
    bit down, up;
    dest = d; a_addr = aa; b_addr = bb; f = ff;
    {ram_lsb_in, ram_msb_in, q_lsb_in, q_msb_in} = sin;
    down = (d == 3'd4 || d == 3'd5);
    up   = (d == 3'd6 || d == 3'd7);
    #(PERIOD/2 - 1);
    // R8: Y selection
    ey = (d == 3'd2) ? m_a : ff;
    if (d != 3'd2 || m_av) chk(d == 3'd2 ? "R8 y shows A" : "R8 y shows F", y, ey);
    // R7, R5, R6: port enables and driven bits
    eoe = {down, up, down, up, 2'b00};
    chk("R7 port enables", {ram_lsb_oe, ram_msb_oe, q_lsb_oe, q_msb_oe},
        {down, up, down, up});
    if (down) chk("R5 down port bits", {2'b00, ram_lsb_out, q_lsb_out}, {2'b00, ff[0], m_q[0]});
    if (up)   chk("R6 up port bits", {2'b00, ram_msb_out, q_msb_out}, {2'b00, ff[W-1], m_q[W-1]});
    // R9 with R4/R2: registered operands reflect earlier writes
    if (m_av) chk("R9 R4 a_data", a_data, m_a);
    if (m_bv) chk("R9 R4 b_data", b_data, m_b);
    @(posedge clk);
    m_a = m_mem[aa]; m_av = m_val[aa];
    m_b = m_mem[bb]; m_bv = m_val[bb];
    rw = down ? {ram_msb_in, ff[W-1:1]} : up ? {ff[W-2:0], ram_lsb_in} : ff;
    if (d >= 3'd2) begin m_mem[bb] = rw; m_val[bb] = 1; end
    case (d)
      3'd0: m_q = ff;
      3'd4: m_q = {q_msb_in, m_q[W-1:1]};
      3'd6: m_q = {m_q[W-2:0], q_lsb_in};
      default: ;
    endcase
    #1;
    case (d)
      3'd0: chk("R1 Q loads F", q_data, m_q);
      3'd4: chk("R5 Q down shift", q_data, m_q);
      3'd6: chk("R6 Q up shift", q_data, m_q);
      3'd1: chk("R2 Q unchanged", q_data, m_q);
      default: chk("R3 Q holds", q_data, m_q);
    endcase
    @(negedge clk);
    if (eoe == 6'd0) ;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_val[i] = 0; m_mem[i] = '0; end
    m_q = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R3 reset clears Q", q_data, '0);

    // Fill the file with unshifted writes (R4)
    for (int i = 0; i < DEPTH; i++) step(3'd3, AW'(0), AW'(i), W'((i * 7 + 3) % 16), 4'b0000);

    // Read-before-write on the same word (R9)
    step(3'd3, 4'd5, 4'd5, 4'hA, 4'b0000);
    step(3'd1, 4'd5, 4'd5, 4'h0, 4'b0000);
    step(3'd1, 4'd5, 4'd5, 4'h0, 4'b0000);
    // Each code with distinct serial bits
    step(3'd0, 4'd1, 4'd2, 4'h9, 4'b0101);   // R1
    step(3'd1, 4'd2, 4'd2, 4'h6, 4'b1111);   // R2
    step(3'd2, 4'd3, 4'd4, 4'hC, 4'b1010);   // R8, R4
    step(3'd4, 4'd4, 4'd6, 4'h5, 4'b0101);   // R5
    step(3'd5, 4'd6, 4'd7, 4'h3, 4'b1010);   // R5
    step(3'd6, 4'd7, 4'd8, 4'hA, 4'b1010);   // R6
    step(3'd7, 4'd8, 4'd9, 4'h6, 4'b0101);   // R6
    for (int i = 0; i < 8; i++) step(3'd1, AW'(i + 2), AW'(i + 4), 4'h0, 4'b0000);

    // Random mix of all codes
    for (int i = 0; i < 2000; i++)
      step(3'($urandom), AW'($urandom), AW'($urandom), W'($urandom), 4'($urandom));

    // Reset in mid-run clears Q (R3)
    rst = 1'b1;
    @(posedge clk); #1;
    m_q = '0;
    chk("R3 reset clears Q", q_data, '0);
    @(negedge clk);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule